// File: doc/BRIEF.md
# Configurable Memory Stack Pointer

This block owns the pointer of a stack held in an ordinary synchronous RAM and turns push and pop requests into single-word RAM accesses. Two static configuration inputs choose the layout. One sets the direction of growth (toward higher or lower addresses). The other says what the pointer holds: the address of the newest stored word ("top" mode) or the address of the next empty word ("free" mode). Together they give four layouts that cannot share one stack image. For each layout the block applies the adjust-then-access or access-then-adjust order that the layout needs.

A requester raises a push (with data) or a pop. The block computes the access address and checks it against an inclusive lower and upper bound. It then performs the access and updates the pointer. Every accepted request takes exactly two cycles and ends with a one-cycle done pulse. Pop data and the overflow or underflow flag are valid in the same cycle as done. An access that would leave the bound window, or that would wrap the address, is blocked: nothing is written or read and the pointer is not moved. While the block is idle, the pointer can be loaded directly. The RAM is a single-port array inside the block, and its address, write data and strobes are brought out at the ports.

Top module: `mem_stack_ptr`

## Requirements
- R1: Reset (rst_n low) clears the pointer to 0. While in reset, busy, done, overflow, underflow, mem_we and mem_re are all 0.
- R2: If ld_en is high on a clock edge while the block is idle, the pointer takes ld_val from the next cycle on, and any push or pop request in that same cycle is dropped. If ld_en is high while the block is busy, the pointer is not changed.
- R3: A request is accepted when the block is idle and ld_en is low. In the cycle after acceptance, busy=1 and done=0. In the cycle after that, busy=1 and done=1. The cycle after that, busy=0. Requests seen while busy are ignored.
- R4: With cfg_grow_up=1, a successful push adds 1 to the pointer and a successful pop subtracts 1 (modulo 2^AW).
- R5: With cfg_grow_up=0, a successful push subtracts 1 from the pointer and a successful pop adds 1 (modulo 2^AW).
- R6: With cfg_free_slot=0 (top mode), a push writes at the pointer after it has been adjusted, and a pop reads at the pointer before it is adjusted.
- R7: With cfg_free_slot=1 (free mode), a push writes at the pointer before it is adjusted, and a pop reads at the pointer after it has been adjusted.
- R8: In the done cycle of a successful pop, pop_data holds the word last pushed to that address. Under each of the four layouts, the stack returns words in last-in, first-out order.
- R9: A push is blocked when its access address lies outside [bound_lo, bound_hi] or would wrap past 0 or past 2^AW-1. In that case mem_we stays 0, the pointer is unchanged, and overflow is 1 during the done cycle only.
- R10: A pop is blocked under the same address rule as R9. In that case mem_re stays 0, the pointer is unchanged, pop_data keeps its previous value, and underflow is 1 during the done cycle only.
- R11: If push_req and pop_req are both high when a request is accepted, the push is performed and the pop is dropped.
- R12: mem_we and mem_re are never high together. A strobe is only high in the first cycle after acceptance. mem_wdata then carries the data that was given with the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_grow_up | input | 1 | 1: stack grows toward higher addresses; 0: toward lower addresses |
| cfg_free_slot | input | 1 | 1: pointer marks the next empty word; 0: pointer marks the newest word |
| bound_lo | input | AW | Lowest address the stack may access |
| bound_hi | input | AW | Highest address the stack may access |
| ld_en | input | 1 | Load the pointer directly (only acted on while idle) |
| ld_val | input | AW | Value to load into the pointer |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| push_data | input | DW | Word to push |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse that ends a request |
| overflow | output | 1 | Push was blocked (valid with done) |
| underflow | output | 1 | Pop was blocked (valid with done) |
| sp | output | AW | Current pointer value |
| mem_addr | output | AW | RAM access address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe |
| pop_data | output | DW | Word returned by the last successful pop |

## Verification
The bench runs all four layouts inside a narrow bound window. It uses push-heavy and then pop-heavy random phases so that the pointer hits both edges of the window many times. A design with the adjust order reversed in one layout would write beside the correct word, so the LIFO readback would return a neighbour or an old value. A design that checks the bounds on the pointer instead of on the access address would stop one word early or late at the window edge. Directed cases cover an address that wraps at the top or the bottom of the address space, which a design without a carry check would treat as valid. They also cover a load and a pop request made while a push is in progress, which a design without proper busy gating would act on, and simultaneous push and pop, where a design with the wrong priority would read instead of write.

// File: rtl/msp_pkg.sv
package msp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EXEC = 2'd1,
      ST_DONE = 2'd2
   } msp_state_e;
endpackage

// File: rtl/msp_addr_calc.sv
module msp_addr_calc #(
   parameter int AW = 6
) (
   input  logic [AW-1:0] sp_cur,
   input  logic          grow_up,
   input  logic          free_slot,
   input  logic          is_push,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic [AW-1:0] acc_addr,
   output logic [AW-1:0] sp_moved,
   output logic          acc_ok
);
   localparam logic [AW:0] ONE_X = {{AW{1'b0}}, 1'b1};

   logic [AW:0] sp_x;
   logic [AW:0] sp_up;
   logic [AW:0] sp_dn;
   logic [AW:0] moved_x;
   logic [AW:0] acc_x;
   logic        step_up;
   logic        adjust_first;

   always_comb begin
      sp_x         = {1'b0, sp_cur};
      sp_up        = sp_x + ONE_X;
      sp_dn        = sp_x - ONE_X;
      // pushes move with the growth direction, pops against it
      step_up      = (is_push == grow_up);
      moved_x      = step_up ? sp_up : sp_dn;
      // top-mode push and free-mode pop touch the adjusted slot
      adjust_first = (is_push != free_slot);
      acc_x        = adjust_first ? moved_x : sp_x;
      acc_addr     = acc_x[AW-1:0];
      sp_moved     = moved_x[AW-1:0];
      acc_ok       = !acc_x[AW] && (acc_x[AW-1:0] >= lo) && (acc_x[AW-1:0] <= hi);
   end
endmodule

// File: rtl/msp_seq.sv
module msp_seq
   import msp_pkg::*;
#(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_val,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic [DW-1:0] push_data,
   input  logic [AW-1:0] calc_addr,
   input  logic [AW-1:0] calc_moved,
   input  logic          calc_ok,
   output logic          calc_push,
   output logic [AW-1:0] sp_q,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic          busy,
   output logic          done,
   output logic          ovf,
   output logic          unf,
   output logic          we,
   output logic          re
);
   msp_state_e state;
   logic       op_push_q;
   logic       ok_q;
   logic       accept;

   always_comb begin
      accept    = (state == ST_IDLE) && !ld_en && (push_req || pop_req);
      // while idle the calculator sees the incoming request, later the latched one
      calc_push = (state == ST_IDLE) ? push_req : op_push_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sp_q      <= '0;
         op_push_q <= 1'b0;
         ok_q      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (ld_en) begin
                  sp_q <= ld_val;
               end else if (accept) begin
                  op_push_q <= push_req;
                  ok_q      <= calc_ok;
                  addr_q    <= calc_addr;
                  wdata_q   <= push_data;
                  state     <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               if (ok_q) sp_q <= calc_moved;
               state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy = (state != ST_IDLE);
      done = (state == ST_DONE);
      we   = (state == ST_EXEC) && op_push_q && ok_q;
      re   = (state == ST_EXEC) && !op_push_q && ok_q;
      ovf  = done && op_push_q && !ok_q;
      unf  = done && !op_push_q && !ok_q;
   end
endmodule

// File: rtl/msp_ram.sv
module msp_ram #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
      if (re) rdata <= cells[addr];
   end
endmodule

// File: rtl/mem_stack_ptr.sv
module mem_stack_ptr #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_grow_up,
   input  logic          cfg_free_slot,
   input  logic [AW-1:0] bound_lo,
   input  logic [AW-1:0] bound_hi,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_val,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic [DW-1:0] push_data,
   output logic          busy,
   output logic          done,
   output logic          overflow,
   output logic          underflow,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic          mem_re,
   output logic [DW-1:0] pop_data
);
   initial begin
      assert (AW >= 2 && AW <= 16) else $fatal(1, "mem_stack_ptr: AW out of range");
      assert (DW >= 1) else $fatal(1, "mem_stack_ptr: DW must be positive");
   end

   logic [AW-1:0] c_addr;
   logic [AW-1:0] c_moved;
   logic          c_ok;
   logic          c_push;

   msp_addr_calc #(.AW(AW)) u_calc (
      .sp_cur    (sp),
      .grow_up   (cfg_grow_up),
      .free_slot (cfg_free_slot),
      .is_push   (c_push),
      .lo        (bound_lo),
      .hi        (bound_hi),
      .acc_addr  (c_addr),
      .sp_moved  (c_moved),
      .acc_ok    (c_ok)
   );

   msp_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_en      (ld_en),
      .ld_val     (ld_val),
      .push_req   (push_req),
      .pop_req    (pop_req),
      .push_data  (push_data),
      .calc_addr  (c_addr),
      .calc_moved (c_moved),
      .calc_ok    (c_ok),
      .calc_push  (c_push),
      .sp_q       (sp),
      .addr_q     (mem_addr),
      .wdata_q    (mem_wdata),
      .busy       (busy),
      .done       (done),
      .ovf        (overflow),
      .unf        (underflow),
      .we         (mem_we),
      .re         (mem_re)
   );

   msp_ram #(.AW(AW), .DW(DW)) u_ram (
      .clk   (clk),
      .we    (mem_we),
      .re    (mem_re),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (pop_data)
   );
endmodule

// File: rtl/msp_checker.sv
module msp_checker #(
   parameter int AW = 6,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_grow_up,
   input logic          cfg_free_slot,
   input logic          ld_en,
   input logic [AW-1:0] ld_val,
   input logic          push_req,
   input logic          pop_req,
   input logic          busy,
   input logic          done,
   input logic          overflow,
   input logic          underflow,
   input logic [AW-1:0] sp,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          mem_re
);
   localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

   AST_SEQ_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ld_en && (push_req || pop_req)) |=> (busy && !done) ##1 (busy && done)); // R3
   AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R3
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ld_en) |=> (sp == $past(ld_val)) && !busy); // R2
   AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (sp == (cfg_grow_up ? $past(sp) + ONE : $past(sp) - ONE))); // R4 R5
   AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> (sp == (cfg_grow_up ? $past(sp) - ONE : $past(sp) + ONE))); // R4 R5
   AST_TOP_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !cfg_free_slot) |=> (sp == $past(mem_addr))); // R6
   AST_TOP_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re && !cfg_free_slot) |-> (mem_addr == sp)); // R6
   AST_FREE_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && cfg_free_slot) |-> (mem_addr == sp)); // R7
   AST_FREE_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_re && cfg_free_slot) |=> (sp == $past(mem_addr))); // R7
   AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> (done && !$past(mem_we) && $stable(sp))); // R9
   AST_NO_UNDERFLOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> (done && !$past(mem_re) && $stable(sp))); // R10
   AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ld_en && push_req && pop_req) |=> !mem_re); // R11
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re)); // R12
   AST_STROBE_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> (busy && !done)); // R12
endmodule

bind mem_stack_ptr msp_checker #(.AW(AW), .DW(DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_grow_up   (cfg_grow_up),
   .cfg_free_slot (cfg_free_slot),
   .ld_en         (ld_en),
   .ld_val        (ld_val),
   .push_req      (push_req),
   .pop_req       (pop_req),
   .busy          (busy),
   .done          (done),
   .overflow      (overflow),
   .underflow     (underflow),
   .sp            (sp),
   .mem_addr      (mem_addr),
   .mem_we        (mem_we),
   .mem_re        (mem_re)
);

// File: tb/mem_stack_ptr_test.sv
`timescale 1ns/1ps
module mem_stack_ptr_test;
   localparam int AW = 6;
   localparam int DW = 16;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_grow_up = 1'b1;
   logic          cfg_free_slot = 1'b0;
   logic [AW-1:0] bound_lo = '0;
   logic [AW-1:0] bound_hi = '1;
   logic          ld_en = 1'b0;
   logic [AW-1:0] ld_val = '0;
   logic          push_req = 1'b0;
   logic          pop_req = 1'b0;
   logic [DW-1:0] push_data = '0;
   logic          busy, done, overflow, underflow, mem_we, mem_re;
   logic [AW-1:0] sp, mem_addr;
   logic [DW-1:0] mem_wdata, pop_data;

   int checks = 0;
   int errors = 0;

   logic [AW-1:0] sp_m;
   logic [DW-1:0] mem_m [DEPTH];
   bit            wr_m  [DEPTH];
   logic [DW-1:0] last_pop;
   bit            last_known = 1'b0;

   always #2.5 clk = ~clk;

   mem_stack_ptr #(.AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_grow_up(cfg_grow_up), .cfg_free_slot(cfg_free_slot),
      .bound_lo(bound_lo), .bound_hi(bound_hi), .ld_en(ld_en), .ld_val(ld_val),
      .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
      .busy(busy), .done(done), .overflow(overflow), .underflow(underflow), .sp(sp),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .pop_data(pop_data)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // access address per layout, with the carry/borrow bit on top
   function automatic logic [AW:0] f_acc(logic [AW-1:0] s, bit up, bit free, bit psh);
      logic [AW:0] x;
      x = {1'b0, s};
      case ({up, free, psh})
         3'b101: return x + 1;   // top, up, push: pre-increment
         3'b100: return x;       // top, up, pop: read current
         3'b111: return x;       // free, up, push: write current
         3'b110: return x - 1;   // free, up, pop: pre-decrement
         3'b001: return x - 1;   // top, down, push: pre-decrement
         3'b000: return x;       // top, down, pop
         3'b011: return x;       // free, down, push
         default: return x + 1;  // free, down, pop: pre-increment
      endcase
   endfunction

   function automatic bit f_ok(logic [AW:0] a);
      return !a[AW] && a[AW-1:0] >= bound_lo && a[AW-1:0] <= bound_hi;
   endfunction

   function automatic logic [AW-1:0] f_next(logic [AW-1:0] s, bit up, bit psh);
      return (psh == up) ? s + 1'b1 : s - 1'b1;
   endfunction

   task automatic load(logic [AW-1:0] v);
      @(negedge clk);
      ld_en = 1'b1; ld_val = v;
      @(negedge clk);
      ld_en = 1'b0;
      sp_m = v;
      chk("R2 load value", sp, v);
      chk("R2 load leaves idle", busy, 0);
   endtask

   task automatic do_op(bit psh, bit pp, logic [DW-1:0] d);
      logic [AW:0]   a;
      bit            ok;
      string         dir_t, mode_t;
      a  = f_acc(sp_m, cfg_grow_up, cfg_free_slot, psh);
      ok = f_ok(a);
      dir_t  = cfg_grow_up ? "R4" : "R5";
      mode_t = cfg_free_slot ? "R7" : "R6";
      @(negedge clk);
      push_req = psh; pop_req = pp; push_data = d;
      @(negedge clk);
      push_req = 1'b0; pop_req = 1'b0;
      chk("R3 busy in first cycle", busy, 1);
      chk("R3 no done in first cycle", done, 0);
      chk(psh ? "R9 R11 write strobe" : "R10 read strobe", {mem_we, mem_re},
          {psh && ok, !psh && ok});
      if (ok) chk({mode_t, " access address"}, mem_addr, a[AW-1:0]);
      if (psh && ok) chk("R12 write data", mem_wdata, d);
      @(negedge clk);
      chk("R3 done in second cycle", {busy, done}, 2'b11);
      chk("R9 overflow flag", overflow, psh && !ok);
      chk("R10 underflow flag", underflow, !psh && !ok);
      if (ok) sp_m = f_next(sp_m, cfg_grow_up, psh);
      chk({dir_t, " pointer after op"}, sp, sp_m);
      if (psh && ok) begin
         mem_m[a[AW-1:0]] = d;
         wr_m[a[AW-1:0]]  = 1'b1;
      end else if (!psh && ok) begin
         if (wr_m[a[AW-1:0]]) begin
            chk("R8 pop data LIFO", pop_data, mem_m[a[AW-1:0]]);
            last_pop = mem_m[a[AW-1:0]];
            last_known = 1'b1;
         end else begin
            last_known = 1'b0;
         end
      end else if (!psh && last_known) begin
         chk("R10 pop data kept", pop_data, last_pop);
      end
      @(negedge clk);
      chk("R3 idle after done", busy, 0);
   endtask

   task automatic set_cfg(bit up, bit free, logic [AW-1:0] lo, logic [AW-1:0] hi);
      @(negedge clk);
      cfg_grow_up = up; cfg_free_slot = free; bound_lo = lo; bound_hi = hi;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) wr_m[i] = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 reset pointer", sp, 0);
      chk("R1 reset status", {busy, done, overflow, underflow, mem_we, mem_re}, 0);
      rst_n = 1'b1;
      sp_m = '0;
      @(negedge clk);
      chk("R1 pointer after release", sp, 0);

      // all four layouts in a narrow window, directed then random
      for (int m = 0; m < 4; m++) begin
         bit up, free;
         up = m[1]; free = m[0];
         set_cfg(up, free, 6'd8, 6'd23);
         if (up) load(free ? 6'd8 : 6'd7);
         else    load(free ? 6'd23 : 6'd24);
         do_op(1, 0, 16'hA000 + 16'(m));
         do_op(1, 0, 16'hB000 + 16'(m));
         do_op(1, 0, 16'hC000 + 16'(m));
         do_op(0, 1, '0);
         do_op(0, 1, '0);
         do_op(0, 1, '0);
         do_op(0, 1, '0);   // empty stack: bound underflow
         for (int k = 0; k < 80; k++) begin
            int r;
            bit psh, pp;
            r   = int'($urandom_range(99));
            psh = (k < 40) ? (r < 65) : (r < 35);
            pp  = !psh || (r % 7 == 0);
            do_op(psh, pp, 16'($urandom));
         end
      end

      // address wrap at the top of the space (R9)
      set_cfg(1, 0, 6'd0, 6'd63);
      load(6'd63);
      do_op(1, 0, 16'h1234);
      chk("R9 no move on wrap", sp, 6'd63);
      // address wrap below zero on pop (R10)
      set_cfg(1, 1, 6'd0, 6'd63);
      load(6'd0);
      do_op(0, 1, '0);
      // push and pop together: push wins (R11)
      do_op(1, 1, 16'h5A5A);
      chk("R11 push taken", sp, 6'd1);

      // load and pop while busy are ignored (R2, R3)
      begin
         logic [AW-1:0] exp_sp;
         exp_sp = f_next(sp_m, 1'b1, 1'b1);
         @(negedge clk);
         push_req = 1'b1; push_data = 16'h7777;
         @(negedge clk);
         push_req = 1'b0; ld_en = 1'b1; ld_val = 6'd40; pop_req = 1'b1;
         @(negedge clk);
         ld_en = 1'b0; pop_req = 1'b0;
         chk("R2 load ignored while busy", sp, exp_sp);
         @(negedge clk);
         chk("R3 idle after busy request", busy, 0);
         @(negedge clk);
         chk("R3 busy request not queued", {busy, sp}, {1'b0, exp_sp});
         sp_m = exp_sp;
      end

      // load has priority over a request in the same cycle (R2)
      @(negedge clk);
      ld_en = 1'b1; ld_val = 6'd33; push_req = 1'b1;
      @(negedge clk);
      ld_en = 1'b0; push_req = 1'b0;
      chk("R2 load wins over push", {busy, sp}, {1'b0, 6'd33});
      @(negedge clk);
      chk("R2 push dropped", {busy, mem_we}, 2'b00);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule